// File: doc/BRIEF.md
# Conditioned Matrix-Vector Product Unit

This block either multiplies a small signed matrix by a vector or passes the vector through unchanged. A one-bit condition arrives with the first vector element. The vector is streamed in first over a valid/ready port and kept in a local store. If the condition is set, the matrix is then streamed in row by row on a second valid/ready port. Each row is reduced to one scalar result by a single multiply-accumulate unit, and that unit is reused for every row. Each result is sent out before the next row is accepted. If the condition is clear, the matrix port stays closed and the stored vector elements are sent out, sign-extended to the output width.

Internally the work is arranged as a conditioned dataflow:
- the matrix stream is split into rows;
- the stored vector is reread for every row;
- a partial sum is carried from column to column and cleared at each row start;
- row results leave in row order.

The two branches each produce their own output tokens, and a priority select merges them onto the output port. The product branch has the higher priority. The output is a valid/ready stream with a last flag on its final element, and it tolerates any pattern of back-pressure.

Top module: `cmv_unit`

## Requirements
- R1: After reset, `out_valid` and `mat_ready` are low and `vec_ready` is high.
- R2: With the condition clear, the output is exactly N_COLS elements. Element k equals vector element k, sign-extended to ACC_W bits, and elements leave in index order.
- R3: With the condition set, the output is exactly M_ROWS elements. Element i is the full-precision signed sum over j of M[i][j]*V[j], with no truncation in ACC_W = 2*DATA_W+clog2(N_COLS) bits. The matrix arrives row-major: row 0 columns 0..N-1 first.
- R4: `out_last` is high on the final output element of a run and low on every other element.
- R5: The matrix port never accepts data (`mat_ready` stays low) unless the condition latched for the current run is set.
- R6: The condition is taken only from `vec_cond` on the handshake of vector element 0. Its value on later vector elements has no effect.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values. No element is lost or reordered under back-pressure.
- R8: Each row result depends only on that row and V. The partial sum is zero at the start of every row.
- R9: The output select forwards exactly one branch token at a time. If both branches present a token, the product branch wins.
- R10: `vec_ready` is low from the last vector element until the run's final output element has been accepted. `out_valid` is low while the vector is being loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vec_valid | input | 1 | Vector element valid |
| vec_ready | output | 1 | Vector element accepted when high with valid |
| vec_data | input | DATA_W | Signed vector element |
| vec_cond | input | 1 | Branch condition, sampled with element 0 (1 = product, 0 = bypass) |
| mat_valid | input | 1 | Matrix element valid |
| mat_ready | output | 1 | Matrix element accepted when high with valid |
| mat_data | input | DATA_W | Signed matrix element, row-major |
| out_valid | output | 1 | Result element valid |
| out_ready | input | 1 | Downstream accepts result |
| out_data | output | ACC_W | Signed result element |
| out_last | output | 1 | Marks the final result element of a run |

## Verification
On every cycle the assertions check four things: output stability under stall, a closed matrix port in bypass, the placement of the last flag against a count of emitted elements, and the exclusion between vector loading and output. They also check that the partial sum is cleared at row starts and that the select grants at most one input, with the product input winning.

Only the bench scenarios can show that the numeric results are correct. The bench computes the sums of products and the sign-extended bypass values arithmetically and sweeps them across extreme operands and several back-pressure patterns. The scenarios also show that a late change of the condition is ignored, and that matrix data offered during a bypass run is left untouched for the next product run.

// File: rtl/cmv_pkg.sv
package cmv_pkg;
   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_LOAD_V = 3'd1,
      ST_MAC    = 3'd2,
      ST_EMIT   = 3'd3,
      ST_DONE   = 3'd4
   } cmv_state_t;

   function automatic int unsigned cmv_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/cmv_vstore.sv
module cmv_vstore #(
   parameter int DEPTH = 4,
   parameter int W     = 16,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] widx,
   input  logic [W-1:0]     wdata,
   input  logic [IDX_W-1:0] ridx,
   output logic [W-1:0]     rdata
);
   logic [DEPTH-1:0][W-1:0] cells;
   logic [DEPTH-1:0][W-1:0] masked;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) cells[i] <= '0;
         else if (we && (widx == IDX_W'(i))) cells[i] <= wdata;
      end
      assign masked[i] = (ridx == IDX_W'(i)) ? cells[i] : '0;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < DEPTH; i++) rdata = rdata | masked[i];
   end
endmodule

// File: rtl/cmv_mac.sv
module cmv_mac #(
   parameter int DATA_W = 16,
   parameter int ACC_W  = 34
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     en,
   input  logic signed [DATA_W-1:0] a,
   input  logic signed [DATA_W-1:0] b,
   output logic signed [ACC_W-1:0]  acc
);
   localparam int PW = 2 * DATA_W;

   logic signed [PW-1:0] prod;
   assign prod = a * b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc <= '0;
      else if (clr) acc <= '0;
      else if (en)  acc <= acc + {{(ACC_W-PW){prod[PW-1]}}, prod};
   end

   assert_row_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc == '0));
endmodule

// File: rtl/cmv_prio_sel.sv
module cmv_prio_sel #(
   parameter int N_IN = 2,
   parameter int W    = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [N_IN-1:0]          in_valid,
   input  logic [N_IN-1:0][W-1:0]   in_data,
   output logic                     out_valid,
   output logic [W-1:0]             out_data
);
   logic [N_IN-1:0]        grant;
   logic [N_IN-1:0][W-1:0] gated;

   always_comb begin
      logic taken;
      taken = 1'b0;
      grant = '0;
      for (int i = 0; i < N_IN; i++) begin
         if (in_valid[i] && !taken) begin
            grant[i] = 1'b1;
            taken    = 1'b1;
         end
      end
   end

   for (genvar i = 0; i < N_IN; i++) begin : g_gate
      assign gated[i] = grant[i] ? in_data[i] : '0;
   end

   always_comb begin
      out_data = '0;
      for (int i = 0; i < N_IN; i++) out_data = out_data | gated[i];
   end
   assign out_valid = |in_valid;

   assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $onehot(grant));
   assert_p1_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid[0] |-> grant[0]);
endmodule

// File: rtl/cmv_unit.sv
module cmv_unit
   import cmv_pkg::*;
#(
   parameter int  M_ROWS = 4,
   parameter int  N_COLS = 4,
   parameter int  DATA_W = 16,
   localparam int ACC_W  = 2 * DATA_W + $clog2(N_COLS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vec_valid,
   output logic              vec_ready,
   input  logic [DATA_W-1:0] vec_data,
   input  logic              vec_cond,
   input  logic              mat_valid,
   output logic              mat_ready,
   input  logic [DATA_W-1:0] mat_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [ACC_W-1:0]  out_data,
   output logic              out_last
);
   localparam int MAXD  = int'(cmv_max(M_ROWS, N_COLS));
   localparam int IDX_W = $clog2(MAXD);
   localparam int CNT_W = IDX_W + 1;
   localparam int TOK_W = ACC_W + 1;

   if (M_ROWS < 2 || N_COLS < 2) begin : g_bad_shape
      $error("cmv_unit: M_ROWS and N_COLS must be at least 2");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("cmv_unit: DATA_W must be at least 2");
   end

   cmv_state_t       state;
   logic             cond_q;
   logic [IDX_W-1:0] col;
   logic [IDX_W-1:0] row;
   logic [CNT_W-1:0] out_cnt;

   logic vec_fire, mat_fire, out_fire;
   logic col_end, prod_end, byp_end;
   assign vec_fire = vec_valid && vec_ready;
   assign mat_fire = mat_valid && mat_ready;
   assign out_fire = out_valid && out_ready;
   assign col_end  = (col == IDX_W'(N_COLS - 1));
   assign prod_end = (row == IDX_W'(M_ROWS - 1));
   assign byp_end  = (row == IDX_W'(N_COLS - 1));

   assign vec_ready = (state == ST_IDLE) || (state == ST_LOAD_V);
   assign mat_ready = (state == ST_MAC);

   // diffusion: one stored copy of V, reread for every row
   logic [IDX_W-1:0]  rd_idx;
   logic [DATA_W-1:0] v_elem;
   assign rd_idx = (state == ST_MAC) ? col : row;

   cmv_vstore #(.DEPTH(N_COLS), .W(DATA_W), .IDX_W(IDX_W)) u_vstore (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (vec_fire),
      .widx  ((state == ST_IDLE) ? '0 : col),
      .wdata (vec_data),
      .ridx  (rd_idx),
      .rdata (v_elem)
   );

   // iterate: partial sum carried across columns, cleared per row
   logic signed [ACC_W-1:0] acc;
   cmv_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (out_fire || (state == ST_IDLE)),
      .en    (mat_fire),
      .a     (mat_data),
      .b     (v_elem),
      .acc   (acc)
   );

   // conditioned branches: each fires only when its data and condition hold
   logic [1:0]              br_valid;
   logic [1:0][TOK_W-1:0]   br_tok;
   logic [TOK_W-1:0]        sel_tok;
   assign br_valid[0] = (state == ST_EMIT) && cond_q;
   assign br_valid[1] = (state == ST_EMIT) && !cond_q;
   assign br_tok[0]   = {prod_end, acc};
   assign br_tok[1]   = {byp_end, {{(ACC_W-DATA_W){v_elem[DATA_W-1]}}, v_elem}};

   cmv_prio_sel #(.N_IN(2), .W(TOK_W)) u_select (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (br_valid),
      .in_data   (br_tok),
      .out_valid (out_valid),
      .out_data  (sel_tok)
   );
   assign out_last = sel_tok[TOK_W-1];
   assign out_data = sel_tok[ACC_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cond_q  <= 1'b0;
         col     <= '0;
         row     <= '0;
         out_cnt <= '0;
      end else begin
         if (out_fire) out_cnt <= out_cnt + 1'b1;
         unique case (state)
            ST_IDLE: if (vec_fire) begin
               cond_q <= vec_cond;
               col    <= IDX_W'(1);
               row    <= '0;
               state  <= ST_LOAD_V;
            end
            ST_LOAD_V: if (vec_fire) begin
               if (col_end) begin
                  col   <= '0;
                  state <= cond_q ? ST_MAC : ST_EMIT;
               end else begin
                  col <= col + 1'b1;
               end
            end
            ST_MAC: if (mat_fire) begin
               if (col_end) begin
                  col   <= '0;
                  state <= ST_EMIT;
               end else begin
                  col <= col + 1'b1;
               end
            end
            ST_EMIT: if (out_fire) begin
               if (out_last) begin
                  state <= ST_DONE;
               end else begin
                  row   <= row + 1'b1;
                  state <= cond_q ? ST_MAC : ST_EMIT;
               end
            end
            ST_DONE: begin
               out_cnt <= '0;
               row     <= '0;
               state   <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
   assert_mat_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      mat_ready |-> cond_q);
   assert_last_place_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> (out_cnt == (cond_q ? CNT_W'(M_ROWS - 1) : CNT_W'(N_COLS - 1))));
   assert_busy_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !vec_ready);
endmodule

// File: tb/cmv_unit_test.sv
module cmv_unit_test;
   localparam int M = 4;
   localparam int N = 4;
   localparam int DW = 16;
   localparam int AW = 2 * DW + $clog2(N);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vec_valid = 1'b0, vec_cond = 1'b0, mat_valid = 1'b0, out_ready = 1'b0;
   logic [DW-1:0] vec_data = '0, mat_data = '0;
   logic vec_ready, mat_ready, out_valid, out_last;
   logic [AW-1:0] out_data;

   always #10 clk = ~clk;

   cmv_unit #(.M_ROWS(M), .N_COLS(N), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n),
      .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data), .vec_cond(vec_cond),
      .mat_valid(mat_valid), .mat_ready(mat_ready), .mat_data(mat_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
   );

   int total = 0, bad = 0, mat_hs = 0, cyc = 0;
   int vv[N];
   int mm[M][N];
   int unsigned seed = 32'h1234_5678;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (mat_valid && mat_ready) mat_hs <= mat_hs + 1;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int rnd();
      seed = seed * 32'd1103515245 + 32'd12345;
      return int'($signed(seed[30:15]));
   endfunction

   task automatic send_vec(input bit cnd, input bit flip_late);
      for (int k = 0; k < N; k++) begin
         @(negedge clk);
         vec_valid = 1'b1;
         vec_data  = DW'(vv[k]);
         vec_cond  = (k == 0) ? cnd : (flip_late ? ~cnd : cnd);
         while (!vec_ready) @(negedge clk);
         if (out_valid) chk("R10 out_valid during load", 64'(out_valid), 64'd0);
         @(posedge clk);
      end
      @(negedge clk);
      vec_valid = 1'b0;
   endtask

   task automatic send_mat();
      for (int i = 0; i < M; i++)
         for (int j = 0; j < N; j++) begin
            @(negedge clk);
            mat_valid = 1'b1;
            mat_data  = DW'(mm[i][j]);
            while (!mat_ready) @(negedge clk);
            @(posedge clk);
         end
      @(negedge clk);
      mat_valid = 1'b0;
   endtask

   task automatic collect(input bit cnd, input int bp);
      int got;
      bit held;
      logic [AW-1:0] hold_d;
      logic hold_l;
      int cnt;
      got = 0;
      held = 0;
      hold_d = '0;
      hold_l = 1'b0;
      cnt = cnd ? M : N;
      while (got < cnt) begin
         @(negedge clk);
         if (held) begin
            chk("R7 valid held under stall", 64'(out_valid), 64'd1);
            chk("R7 data held under stall", 64'(out_data), 64'(hold_d));
            chk("R7 last held under stall", 64'(out_last), 64'(hold_l));
         end
         case (bp)
            0: out_ready = 1'b1;
            1: out_ready = (cyc % 3) != 0;
            default: out_ready = (cyc % 5) >= 3;
         endcase
         held = 0;
         if (out_valid) chk("R10 vec_ready busy", 64'(vec_ready), 64'd0);
         if (out_valid && !out_ready) begin
            held = 1;
            hold_d = out_data;
            hold_l = out_last;
         end
         if (out_valid && out_ready) begin
            logic [63:0] e;
            if (cnd) begin
               longint s;
               s = 0;
               for (int j = 0; j < N; j++) s += longint'(mm[got][j]) * longint'(vv[j]);
               e = 64'(s);
               chk("R3 R8 row result", 64'(out_data), 64'(e[AW-1:0]));
            end else begin
               e = 64'(longint'(vv[got]));
               chk("R2 bypass element", 64'(out_data), 64'(e[AW-1:0]));
            end
            chk("R4 last flag", 64'(out_last), 64'(got == cnt - 1));
            got++;
         end
      end
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic run(input bit cnd, input bit flip_late, input int bp);
      int hs0;
      @(negedge clk);
      hs0 = mat_hs;
      if (!cnd) begin
         mat_valid = 1'b1;
         mat_data  = DW'(16'h7abc);
      end
      fork
         send_vec(cnd, flip_late);
         begin
            if (cnd) send_mat();
         end
         collect(cnd, bp);
      join
      repeat (2) @(negedge clk);
      if (!cnd) begin
         chk("R5 no matrix taken in bypass", 64'(mat_hs - hs0), 64'd0);
         mat_valid = 1'b0;
      end else begin
         chk("R3 matrix count", 64'(mat_hs - hs0), 64'(M * N));
      end
      chk("R10 idle again", 64'(vec_ready), 64'd1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 out_valid reset", 64'(out_valid), 64'd0);
      chk("R1 mat_ready reset", 64'(mat_ready), 64'd0);
      chk("R1 vec_ready reset", 64'(vec_ready), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);
      mat_valid = 1'b1;
      @(negedge clk);
      chk("R5 mat_ready idle", 64'(mat_ready), 64'd0);
      chk("R9 no token idle", 64'(out_valid), 64'd0);
      mat_valid = 1'b0;

      // bypass with extreme values
      vv = '{1, -1, 32767, -32768};
      run(1'b0, 1'b0, 0);
      // extreme product: every operand most negative
      for (int i = 0; i < M; i++) for (int j = 0; j < N; j++) mm[i][j] = -32768;
      vv = '{-32768, -32768, -32768, -32768};
      run(1'b1, 1'b0, 1);
      // mixed signs, distinct rows (accumulator clear per row)
      for (int i = 0; i < M; i++) for (int j = 0; j < N; j++) mm[i][j] = (i == j) ? 32767 : -(i + 1) * 100;
      vv = '{32767, -32768, 5, -7};
      run(1'b1, 1'b0, 2);
      // condition flips after element 0: R6
      vv = '{3, -4, 5, -6};
      run(1'b1, 1'b1, 0);
      run(1'b0, 1'b1, 1);
      // sweep of pseudo-random runs, both branches, all stall patterns
      for (int r = 0; r < 12; r++) begin
         for (int i = 0; i < M; i++) for (int j = 0; j < N; j++) mm[i][j] = rnd();
         for (int j = 0; j < N; j++) vv[j] = rnd();
         run(1'(r % 2 == 0), 1'(r % 3 == 0), r % 3);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule